// File: doc/BRIEF.md
# SDRAM Refresh Request Scheduler

This block issues auto-refresh requests to the command side of an external SDRAM interface. A free-running interval timer counts controller clock cycles up to a programmable 10-bit period. Each time the timer expires, one refresh becomes due and the timer reloads at once. The timer does not wait for the refresh to be carried out.

A due refresh is not issued at once if the memory bus is occupied by another access. Instead the block adds it to a small pending count. The request output is raised whenever that count is non-zero and the bus is free. The command sequencer answers each refresh it performs with a one-cycle done pulse, and each pulse retires one pending refresh. Refreshes that piled up during a long access are therefore served back to back once the bus is released. At most four can wait; due refreshes beyond that are discarded. A period of zero turns generation off.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With a non-zero period P and the bus idle, the first refresh request appears after exactly P rising clock edges following reset release, and a refresh falls due every P cycles after that; any period from 1 to 1023 is valid.
- R2: The interval timer keeps running and reloads on every expiry regardless of bus state or pending count, so each expiry during a busy bus adds one pending refresh.
- R3: `ref_req_o` is high exactly when at least one refresh is pending and `bus_busy_i` is low; a busy bus masks the request without losing it.
- R4: Each cycle with `ref_done_i` high retires one pending refresh; pending refreshes are requested back to back until the count reaches zero.
- R5: No more than four refreshes are held pending; a refresh falling due while four are held is lost.
- R6: A due refresh and a done pulse in the same cycle leave the pending count unchanged; a done pulse with nothing pending is ignored.
- R7: A period of zero stops the timer, and no new refreshes fall due while it is zero.
- R8: Asserting `rst_ni` low clears the timer and the pending count, so `ref_req_o` is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| period_i | input | 10 | Refresh interval in clock cycles; 0 disables |
| bus_busy_i | input | 1 | External memory bus occupied by another access |
| ref_done_i | input | 1 | One-cycle pulse: a refresh has been performed |
| ref_req_o | output | 1 | Refresh request to the command sequencer |

## Verification
On every cycle, the assertions check four properties: the pending count never exceeds four, it never wraps below zero, a coincident due and done leave it unchanged, and the timer stays parked at zero while the period is zero. They also check that the timer restarts after every expiry and stays below a stable period, and that a refresh which has just fallen due is requested whenever the bus is idle. Some behaviour can only be shown by the bench scenarios, because it depends on long stretches of stimulus. These are: the exact cycle of the first request for short and full-scale periods, the dropping of a fifth refresh that falls due while the bus is busy, and the back-to-back draining once the bus frees.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;
  localparam int unsigned PERIOD_W_DEF = 10;
  localparam int unsigned MAX_PEND_DEF = 4;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned PERIOD_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                due_o
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                enabled;
  logic                expire;

  assign enabled = (period_i != '0);
  // >= so a period shrunk below the running count expires at once
  assign expire  = enabled && (cnt_q >= (period_i - 1'b1));
  assign due_o   = expire;

  always_comb begin
    cnt_d = cnt_q;
    if (!enabled)    cnt_d = '0;
    else if (expire) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o |=> (cnt_q == '0));

  assert_parked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |=> (cnt_q == '0));

  assert_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i != '0 && $stable(period_i)) |-> (cnt_q < period_i));
endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
  parameter int unsigned MAX_PEND = 4,
  localparam int unsigned CW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          done_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_PEND);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          dec;
  logic          full;

  assign dec  = done_i && (cnt_q != '0);
  assign full = (cnt_q == MAX_C);

  always_comb begin
    cnt_d = cnt_q;
    unique case ({inc_i, dec})
      2'b10:   if (!full) cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_C);

  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !inc_i) |=> (cnt_q == '0));

  assert_coincident_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && done_i && cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_ref_pkg::*;
#(
  parameter int unsigned PERIOD_W = PERIOD_W_DEF,
  parameter int unsigned MAX_PEND = MAX_PEND_DEF,
  localparam int unsigned CW = $clog2(MAX_PEND + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                bus_busy_i,
  input  logic                ref_done_i,
  output logic                ref_req_o
);
  logic          due;
  logic [CW-1:0] pend_cnt;

  ref_interval_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period_i),
    .due_o   (due)
  );

  ref_pending_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (due),
    .done_i(ref_done_i),
    .cnt_o (pend_cnt)
  );

  assign ref_req_o = (pend_cnt != '0) && !bus_busy_i;

  // a refresh that just fell due must be visible on an idle bus
  assert_due_served_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(due) && !bus_busy_i) |-> ref_req_o);
endmodule

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] period_i = '0;
  logic       bus_busy_i = 1'b0;
  logic       ref_done_i = 1'b0;
  logic       ref_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sdram_refresh_sched u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .period_i  (period_i),
    .bus_busy_i(bus_busy_i),
    .ref_done_i(ref_done_i),
    .ref_req_o (ref_req_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ref_req_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic do_reset(input logic [9:0] p, input logic busy);
    rst_ni = 1'b0;
    period_i = p;
    bus_busy_i = busy;
    ref_done_i = 1'b0;
    step(2);
    rst_ni = 1'b1;
  endtask

  task automatic done_pulse();
    ref_done_i = 1'b1;
    step(1);
    ref_done_i = 1'b0;
  endtask

  task automatic t_basic();
    do_reset(10'd5, 1'b0);
    chk(ref_req_o, 1'b0, "R8 after reset");
    step(4);
    chk(ref_req_o, 1'b0, "R1 before P edges");
    step(1);
    chk(ref_req_o, 1'b1, "R1 at P edges");
    done_pulse();
    chk(ref_req_o, 1'b0, "R4 retired by done");
  endtask

  task automatic t_coincide();
    do_reset(10'd5, 1'b0);
    step(5);
    step(4);
    chk(ref_req_o, 1'b1, "R6 pending before coincidence");
    done_pulse();
    chk(ref_req_o, 1'b1, "R6 due+done keep count");
    done_pulse();
    chk(ref_req_o, 1'b0, "R6 drained after coincidence");
  endtask

  task automatic t_saturate();
    do_reset(10'd5, 1'b1);
    step(30);
    chk(ref_req_o, 1'b0, "R3 masked while busy");
    period_i = '0;
    bus_busy_i = 1'b0;
    #1;
    chk(ref_req_o, 1'b1, "R3 request once bus free");
    for (int i = 0; i < 4; i++) begin
      done_pulse();
      if (i < 3) chk(ref_req_o, 1'b1, "R4 back-to-back pending");
      else       chk(ref_req_o, 1'b0, "R5 only four kept");
    end
  endtask

  task automatic t_disabled();
    do_reset(10'd0, 1'b0);
    step(2000);
    chk(ref_req_o, 1'b0, "R7 period zero idle");
    done_pulse();
    chk(ref_req_o, 1'b0, "R6 done at zero ignored");
    period_i = 10'd5;
    step(4);
    chk(ref_req_o, 1'b0, "R6 no wrap before due");
    step(1);
    chk(ref_req_o, 1'b1, "R7 resumes after enable");
  endtask

  task automatic t_busy_count();
    do_reset(10'd5, 1'b1);
    step(10);
    period_i = '0;
    bus_busy_i = 1'b0;
    #1;
    chk(ref_req_o, 1'b1, "R2 pending after busy");
    done_pulse();
    chk(ref_req_o, 1'b1, "R2 second expiry counted");
    done_pulse();
    chk(ref_req_o, 1'b0, "R2 exactly two expiries");
  endtask

  task automatic t_full_scale();
    do_reset(10'd1023, 1'b0);
    step(1022);
    chk(ref_req_o, 1'b0, "R1 full-scale before");
    step(1);
    chk(ref_req_o, 1'b1, "R1 full-scale at P");
    rst_ni = 1'b0;
    #1;
    chk(ref_req_o, 1'b0, "R8 async reset clears");
  endtask

  initial begin
    t_basic();
    t_coincide();
    t_saturate();
    t_disabled();
    t_busy_count();
    t_full_scale();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule